// File: doc/BRIEF.md
# Source/Sink Signal Pattern Sequencer

The sequencer replays a stored pattern of eight timing signals at one entry per clock and, at the same time if asked, records eight incoming signals per clock. Two memories of equal depth hold the data: a source memory that feeds the outputs and a sink memory that receives the samples. The host sees them as one 16-bit word space, with the source entry in the low byte and the sink entry in the high byte of each word.

The host uses a small register port. One register holds the per-output enables, the cyclic flag, and a level reset plus an edge start for each engine. A second register holds the end address. A separate memory strobe with a word address writes pattern data. The read port returns the word at the current address one clock later. A run covers addresses zero to the end address and then either stops or, in cyclic mode, returns to zero. A sink start launches both engines in lockstep, so each captured sample lines up with a known played entry.

The memory depth is set by the address width parameter. The default is kept small. An address width of 14 gives the full 16K-entry memories.

Top module: `pattern_sequencer`

## Requirements
- R1: After reset, `sig_out` is zero, both busy flags are low, and the control and end-address registers are zero.
- R2: A host memory write stores `host_wdata[7:0]` as the source entry and `host_wdata[15:8]` as the sink entry at `mem_addr`. `mem_rdata` returns `{sink, source}` for the address presented one clock earlier.
- R3: The source byte maps onto `sig_out` as follows: bit 0 trigger, bit 1 event-counter reset, bit 2 bunch-counter reset, bit 3 calibrate, bit 4 serial ID, bit 5 serial trigger type, bit 6 front-end reset, bit 7 spare. If a start takes effect at clock edge E, entry k appears on `sig_out` after edge E+1+k.
- R4: A run covers end address + 1 entries. Without cyclic mode, `src_busy` falls after the last entry and `sig_out` returns to zero one clock later.
- R5: With the cyclic flag set, the address wraps from the end address to zero and the engine keeps running.
- R6: Control register (`reg_sel`=0) bit 10 is the source start. A start happens only when a write changes this bit from 0 to 1. Rewriting a 1 does not start or restart the engine.
- R7: Control bits 7:0 are level enables, one per output. A cleared enable forces its output low at once, whatever the memory holds.
- R8: Control bit 12 is the sink start and acts on its 0-to-1 write. It starts both engines at address zero. While the sink runs, `sig_in` sampled at each edge is written to the current sink address: entry k holds the value sampled at edge E+1+k.
- R9: Control bit 9 (source reset) and bit 11 (sink reset) are level resets. While set, the engine is held idle and start edges are ignored. Bit 8 is the cyclic flag.
- R10: A host memory write leaves the source lane unchanged while the source runs, and the sink lane unchanged while the sink runs.
- R11: Reset does not clear memory contents. Data written before a reset reads back unchanged after it.
- R12: The end-address register (`reg_sel`=1) takes `host_wdata[AW-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects end address |
| host_wdata | input | 16 | Write data for registers and memory |
| mem_we | input | 1 | Memory write strobe |
| mem_addr | input | AW | Memory word address for writes and reads |
| mem_rdata | output | 16 | Sink and source entries, registered |
| sig_in | input | 8 | Signals captured by the sink |
| sig_out | output | 8 | Gated source signals |
| src_busy | output | 1 | Source engine running |
| snk_busy | output | 1 | Sink engine running |

## Verification
The assertions assume the end address is not lowered below the current address during a run. The bench keeps to this by changing the end address only while both engines are idle. They also assume the host does not change control bits and the end address in the same clock, since the port takes one register write per clock. The stimulus issues a single write per clock and holds inputs stable across each edge.

// File: rtl/pattern_sequencer.sv
module pattern_sequencer #(
  parameter int AW = 8,
  parameter int SW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [2*SW-1:0] host_wdata,
  input  logic            mem_we,
  input  logic [AW-1:0]   mem_addr,
  output logic [2*SW-1:0] mem_rdata,
  input  logic [SW-1:0]   sig_in,
  output logic [SW-1:0]   sig_out,
  output logic            src_busy,
  output logic            snk_busy
);
  localparam int DEPTH   = 1 << AW;
  localparam int CYC     = SW;
  localparam int SRC_RST = SW + 1;
  localparam int SRC_GO  = SW + 2;
  localparam int SNK_RST = SW + 3;
  localparam int SNK_GO  = SW + 4;
  localparam int CW      = SW + 5;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [SW-1:0] src_mem [DEPTH];
  logic [SW-1:0] snk_mem [DEPTH];

  logic [CW-1:0] ctrl_q;
  logic [AW-1:0] end_q, src_addr, snk_addr;
  logic          src_run, snk_run;
  logic [SW-1:0] pat_q;

  wire ctrl_wr = reg_we & ~reg_sel;
  wire end_wr  = reg_we &  reg_sel;
  wire [CW-1:0] ctrl_nx = ctrl_wr ? host_wdata[CW-1:0] : ctrl_q;

  wire src_hold = ctrl_nx[SRC_RST];
  wire snk_hold = ctrl_nx[SNK_RST];
  wire src_edge = ctrl_wr & host_wdata[SRC_GO] & ~ctrl_q[SRC_GO];
  wire snk_edge = ctrl_wr & host_wdata[SNK_GO] & ~ctrl_q[SNK_GO];
  wire snk_go   = snk_edge & ~snk_hold;
  wire src_go   = (src_edge | snk_go) & ~src_hold;
  wire src_last = (src_addr == end_q);
  wire snk_last = (snk_addr == end_q);
  wire cyc      = ctrl_q[CYC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      end_q  <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
      if (end_wr) end_q <= host_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_run  <= 1'b0;
      src_addr <= '0;
      pat_q    <= '0;
    end else begin
      pat_q <= src_run ? src_mem[src_addr] : '0;
      if (src_hold) begin
        src_run  <= 1'b0;
        src_addr <= '0;
      end else if (src_go) begin
        src_run  <= 1'b1;
        src_addr <= '0;
      end else if (src_run) begin
        if (src_last) begin
          src_addr <= '0;
          src_run  <= cyc;
        end else begin
          src_addr <= src_addr + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snk_run  <= 1'b0;
      snk_addr <= '0;
    end else begin
      if (snk_hold) begin
        snk_run  <= 1'b0;
        snk_addr <= '0;
      end else if (snk_go) begin
        snk_run  <= 1'b1;
        snk_addr <= '0;
      end else if (snk_run) begin
        if (snk_last) begin
          snk_addr <= '0;
          snk_run  <= cyc;
        end else begin
          snk_addr <= snk_addr + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we && !src_run) src_mem[mem_addr] <= host_wdata[SW-1:0];
    if (snk_run)
      snk_mem[snk_addr] <= sig_in;
    else if (mem_we)
      snk_mem[mem_addr] <= host_wdata[2*SW-1:SW];
    mem_rdata <= {snk_mem[mem_addr], src_mem[mem_addr]};
  end

  assign sig_out  = pat_q & ctrl_q[SW-1:0];
  assign src_busy = src_run;
  assign snk_busy = snk_run;

  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    src_run && src_last && !cyc && !src_go |=> !src_run); // R4
  AST_WRAP_CYCLIC: assert property (@(posedge clk) disable iff (!rst_n)
    src_run && src_last && cyc && !src_hold |=> src_run && src_addr == '0); // R5
  AST_NO_LEVEL_START: assert property (@(posedge clk) disable iff (!rst_n)
    !src_run && !src_edge && !snk_edge |=> !src_run); // R6
  AST_SINK_LAUNCHES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    snk_go && !src_hold |=> src_run && snk_run && snk_addr == '0); // R8
  AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[SRC_RST] |-> !src_run); // R9
  AST_SNK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[SNK_RST] |-> !snk_run); // R9
endmodule

// File: tb/sim_pattern_sequencer.sv
module sim_pattern_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0, mem_we = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [7:0]  mem_addr = '0;
  logic [15:0] mem_rdata;
  logic [7:0]  sig_in = '0;
  logic [7:0]  sig_out;
  logic        src_busy, snk_busy;

  always #4 clk = ~clk;

  pattern_sequencer #(.AW(8), .SW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .host_wdata(host_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .sig_in(sig_in), .sig_out(sig_out),
    .src_busy(src_busy), .snk_busy(snk_busy));

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";
  bit live = 0, rd_live = 0;

  logic [7:0]  m_src [256];
  logic [7:0]  m_snk [256];
  logic [12:0] m_ctrl = '0, nctrl;
  logic [7:0]  m_end = '0, m_sadr = '0, m_kadr = '0, m_pat = '0;
  logic        m_srun = 0, m_krun = 0;
  logic [15:0] m_rd = '0;
  bit cw, sedge, kedge, kgo, sgo;

  function automatic logic [7:0] fill_src(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] fill_snk(int a);
    return 8'((a ^ 8'hC3) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_end = '0; m_srun = 0; m_sadr = '0;
      m_krun = 0; m_kadr = '0; m_pat = '0;
    end else begin
      cw    = reg_we && !reg_sel;
      nctrl = cw ? host_wdata[12:0] : m_ctrl;
      sedge = cw && host_wdata[10] && !m_ctrl[10];
      kedge = cw && host_wdata[12] && !m_ctrl[12];
      kgo   = kedge && !nctrl[11];
      sgo   = (sedge || kgo) && !nctrl[9];
      m_rd  = {m_snk[mem_addr], m_src[mem_addr]};
      m_pat = m_srun ? m_src[m_sadr] : 8'h00;
      if (mem_we && !m_srun) m_src[mem_addr] = host_wdata[7:0];
      if (m_krun) m_snk[m_kadr] = sig_in;
      else if (mem_we) m_snk[mem_addr] = host_wdata[15:8];
      if (nctrl[9]) begin m_srun = 0; m_sadr = 0; end
      else if (sgo) begin m_srun = 1; m_sadr = 0; end
      else if (m_srun) begin
        if (m_sadr == m_end) begin m_sadr = 0; m_srun = m_ctrl[8]; end
        else m_sadr = m_sadr + 8'd1;
      end
      if (nctrl[11]) begin m_krun = 0; m_kadr = 0; end
      else if (kgo) begin m_krun = 1; m_kadr = 0; end
      else if (m_krun) begin
        if (m_kadr == m_end) begin m_kadr = 0; m_krun = m_ctrl[8]; end
        else m_kadr = m_kadr + 8'd1;
      end
      m_ctrl = nctrl;
      if (reg_we && reg_sel) m_end = host_wdata[7:0];
    end
  end

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", r, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (live && rst_n) begin
      chk(cur_req, {8'h00, sig_out}, {8'h00, m_pat & m_ctrl[7:0]});
      chk(cur_req, {14'h0, src_busy, snk_busy}, {14'h0, m_srun, m_krun});
      if (rd_live) chk(cur_req, mem_rdata, m_rd);
    end
    if (cycles > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial forever begin
    @(negedge clk);
    sig_in = sig_in + 8'd13;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wreg(bit sel, logic [15:0] v);
    @(negedge clk); reg_we = 1; reg_sel = sel; host_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic wmem(int a, logic [15:0] v);
    @(negedge clk); mem_we = 1; mem_addr = 8'(a); host_wdata = v;
    @(negedge clk); mem_we = 0;
  endtask
  task automatic rd(int a);
    @(negedge clk); mem_addr = 8'(a);
    @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk("R1", {sig_out, 6'h0, src_busy, snk_busy}, 16'h0000);
    @(negedge clk); rst_n = 1;
    live = 1;
    cur_req = "R2";
    for (int a = 0; a < 256; a++) wmem(a, {fill_snk(a), fill_src(a)});
    rd_live = 1;
    rd(17);
    chk("R2", mem_rdata, {fill_snk(17), fill_src(17)});

    cur_req = "R3";
    wreg(1, 16'h0005);
    wreg(0, 16'h04FF);
    chk("R3", {15'h0, src_busy}, 16'h0001);
    @(negedge clk);
    chk("R3", {8'h00, sig_out}, {8'h00, fill_src(0)});
    idle(8);
    chk("R4", {15'h0, src_busy}, 16'h0000);
    chk("R4", {8'h00, sig_out}, 16'h0000);
    wreg(0, 16'h00FF);

    cur_req = "R6";
    wreg(0, 16'h04FF);
    idle(1);
    wreg(0, 16'h04FF);
    idle(8);
    chk("R6", {15'h0, src_busy}, 16'h0000);
    wreg(0, 16'h04FF);
    idle(3);
    chk("R6", {15'h0, src_busy}, 16'h0000);
    wreg(0, 16'h00FF);

    cur_req = "R5";
    wreg(1, 16'h0003);
    wreg(0, 16'h05FF);
    idle(20);
    chk("R5", {15'h0, src_busy}, 16'h0001);

    cur_req = "R9";
    wreg(0, 16'h03FF);
    chk("R9", {15'h0, src_busy}, 16'h0000);
    wreg(0, 16'h07FF);
    idle(2);
    chk("R9", {15'h0, src_busy}, 16'h0000);
    wreg(0, 16'h00FF);

    cur_req = "R7";
    wreg(0, 16'h050F);
    idle(6);
    wreg(0, 16'h05A0);
    idle(6);
    wreg(0, 16'h01A0);
    idle(4);
    chk("R7", {15'h0, src_busy}, 16'h0001);
    wreg(0, 16'h0200);
    idle(2);
    chk("R7", {8'h00, sig_out}, 16'h0000);
    wreg(0, 16'h00FF);

    cur_req = "R8";
    wreg(1, 16'h0009);
    chk("R12", {15'h0, src_busy}, 16'h0000);
    wreg(0, 16'h10FF);
    chk("R8", {14'h0, src_busy, snk_busy}, 16'h0003);
    idle(15);
    chk("R4", {14'h0, src_busy, snk_busy}, 16'h0000);
    for (int a = 0; a < 10; a++) begin
      rd(a);
      chk("R8", mem_rdata, m_rd);
    end
    wreg(0, 16'h00FF);

    cur_req = "R10";
    wreg(1, 16'h0003);
    wreg(0, 16'h11FF);
    idle(2);
    wmem(2, 16'hFFFF);
    wreg(0, 16'h0AFF);
    rd(2);
    chk("R10", {8'h00, mem_rdata[7:0]}, {8'h00, fill_src(2)});
    chk("R10", mem_rdata, m_rd);
    wreg(0, 16'h00FF);

    cur_req = "R11";
    wmem(7, 16'h1234);
    @(negedge clk); rst_n = 0; live = 0;
    idle(2);
    chk("R1", {sig_out, 6'h0, src_busy, snk_busy}, 16'h0000);
    @(negedge clk); rst_n = 1; live = 1;
    rd(7);
    chk("R11", mem_rdata, 16'h1234);
    wreg(0, 16'h0400);
    @(negedge clk);
    chk("R1", {8'h00, sig_out}, 16'h0000);
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule